// File: doc/BRIEF.md
# Cascadable CAM Status Flag Slice

This block is one slice of a small content-addressable memory that can be stacked vertically with identical slices. It keeps a parameterised array of key entries, each with its own valid bit. A write stores a key into the lowest-numbered empty entry. A compare strobe checks a key against every valid entry. One clock later the slice reports, on active-low flags, whether at least one entry matched and whether more than one matched.

The slice takes part in two daisy chains. The match-priority chain ORs this slice's own match into the active-low signal passed downstream, so lower slices can tell that a higher-priority slice has already hit. The full chain reports system fullness. When full generation is enabled in the slice's control register, the full output drops only when this slice has no empty entry and everything upstream is full. When it is disabled, the full output repeats the full input. The top slice of a chain ties its match input high and its full input low. The bottom slice's full output is the system-full signal. A slice whose full input is low and whose full output is high holds the chain's next free address and raises a local indication.

The match flags are held by a small state machine with three states. FLG_NONE means no match. FLG_ONE means exactly one match. FLG_MANY means two or more matches. The transitions are as follows:
- compare with zero hits → FLG_NONE
- compare with one hit → FLG_ONE
- compare with two or more hits → FLG_MANY
- register-set switch → FLG_NONE, from any state, with priority over a compare in the same cycle
- no event → hold the current state
- reset → FLG_NONE

Top module: `cam_slice_flags`

## Requirements
- R1: After a clock edge with `rst_n` low, all entries are invalid, `dev_match_n` and `dev_multi_n` are 1, full generation is enabled and `free_index` is 0.
- R2: A write with `wr_en` high stores `wr_key` in the lowest-index invalid entry and sets its valid bit. `free_index` then shows the next invalid entry, or 0 when all entries are valid. A write while all entries are valid has no effect.
- R3: In the cycle after a clock edge that samples `cmp_en` high, `dev_match_n` is 0 if at least one valid entry equals `cmp_key`, and 1 otherwise. Invalid entries never match.
- R4: In the cycle after a compare, `dev_multi_n` is 0 only if two or more valid entries equal `cmp_key`.
- R5: Both match flags keep their value through cycles without a compare or a register-set switch.
- R6: `dev_match_n` and `dev_multi_n` do not depend on `match_in_n`.
- R7: A change of `bank_sel` sampled at a clock edge drives both match flags to 1 from that edge on. This takes priority over a compare sampled at the same edge.
- R8: `match_out_n` is 0 when `match_in_n` is 0 or `dev_match_n` is 0, and 1 otherwise.
- R9: With full generation enabled, `full_out_n` is 0 exactly when all entries are valid and `full_in_n` is 0.
- R10: A clock edge with `ctl_we` high loads `ctl_full_en` into the full-generation enable. While it is 0, `full_out_n` equals `full_in_n`.
- R11: `holds_next_free` is 1 exactly when `full_in_n` is 0 and `full_out_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe into the next free entry |
| wr_key | input | KEY_W | Key to store |
| cmp_en | input | 1 | Compare strobe |
| cmp_key | input | KEY_W | Key to search for |
| bank_sel | input | 1 | Active register-set select; any change clears the match flags |
| ctl_we | input | 1 | Control register write strobe |
| ctl_full_en | input | 1 | Full-generation enable value for the control register |
| match_in_n | input | 1 | Match-priority input from the slice above, active low |
| full_in_n | input | 1 | Full input from the slice above, active low |
| dev_match_n | output | 1 | Slice match flag, active low |
| dev_multi_n | output | 1 | Slice multiple-match flag, active low |
| match_out_n | output | 1 | Match-priority output to the slice below, active low |
| full_out_n | output | 1 | Full output to the slice below, active low |
| holds_next_free | output | 1 | This slice holds the chain's next free address |
| free_index | output | $clog2(ENTRIES) | Lowest invalid entry index |

## Verification
The bench uses the default build: eight entries and 16-bit keys. With eight entries, the array can be filled in a few writes. That brings the full-slice boundary, the write ignored when full, and the full-chain outputs into the same short run as the matching tests. Duplicate keys in the small array give both the single-hit and the multiple-hit outcome. Key 0 is compared against entries that have never been written, which shows that invalid entries do not hit.

// File: rtl/cam_flag_pkg.sv
package cam_flag_pkg;

    typedef enum logic [1:0] {
        FLG_NONE = 2'd0,
        FLG_ONE  = 2'd1,
        FLG_MANY = 2'd2
    } flag_state_t;

endpackage

// File: rtl/cam_store.sv
module cam_store #(
    parameter int ENTRIES = 8,
    parameter int KEY_W   = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [KEY_W-1:0]                  wr_key,
    output logic [ENTRIES-1:0]                valid,
    output logic [ENTRIES-1:0][KEY_W-1:0]     data,
    output logic [IDX_W-1:0]                  free_idx,
    output logic                              all_valid
);

    always_comb begin
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid[i]) free_idx = IDX_W'(i);
        end
    end

    assign all_valid = &valid;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= '0;
        end else if (wr_en && !all_valid) begin
            valid[free_idx] <= 1'b1;
            data[free_idx]  <= wr_key;
        end
    end

    // R2: an accepted write adds exactly one valid entry
    a_r2_write_adds_one: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !all_valid) |=> ($countones(valid) == $countones($past(valid)) + 1));

    // R2: a write into a full slice changes nothing
    a_r2_full_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && all_valid) |=> $stable(valid));

endmodule

// File: rtl/cam_compare.sv
module cam_compare #(
    parameter int ENTRIES = 8,
    parameter int KEY_W   = 16,
    localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
    input  logic [ENTRIES-1:0]            valid,
    input  logic [ENTRIES-1:0][KEY_W-1:0] data,
    input  logic [KEY_W-1:0]              key,
    output logic [CNT_W-1:0]              hit_cnt
);

    logic [ENTRIES-1:0] hit;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_lane
        assign hit[g] = valid[g] && (data[g] == key);
    end

    always_comb begin
        hit_cnt = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            hit_cnt = hit_cnt + CNT_W'(hit[i]);
        end
    end

endmodule

// File: rtl/cam_flag_fsm.sv
module cam_flag_fsm
    import cam_flag_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_en,
    input  logic [CNT_W-1:0] hit_cnt,
    input  logic             bank_sel,
    output logic             match_n,
    output logic             multi_n
);

    flag_state_t state, state_nx;
    logic        sel_q;
    logic        sel_chg;

    assign sel_chg = (bank_sel != sel_q);

    always_comb begin
        state_nx = state;
        if (sel_chg) begin
            state_nx = FLG_NONE;
        end else if (cmp_en) begin
            if (hit_cnt == '0)      state_nx = FLG_NONE;
            else if (hit_cnt == 1)  state_nx = FLG_ONE;
            else                    state_nx = FLG_MANY;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= FLG_NONE;
            sel_q <= bank_sel;
        end else begin
            state <= state_nx;
            sel_q <= bank_sel;
        end
    end

    always_comb begin
        unique case (state)
            FLG_NONE: begin match_n = 1'b1; multi_n = 1'b1; end
            FLG_ONE:  begin match_n = 1'b0; multi_n = 1'b1; end
            FLG_MANY: begin match_n = 1'b0; multi_n = 1'b0; end
            default:  begin match_n = 1'b1; multi_n = 1'b1; end
        endcase
    end

    a_r3_hit_sets_match: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_en && hit_cnt != '0 && !sel_chg) |=> !match_n);

    a_r3_miss_clears_match: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_en && hit_cnt == '0) |=> match_n);

    a_r4_many_sets_multi: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_en && hit_cnt > 1 && !sel_chg) |=> !multi_n);

    a_r7_switch_clears: assert property (@(posedge clk) disable iff (!rst_n)
        sel_chg |=> (match_n && multi_n));

    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmp_en && !sel_chg) |=> ($stable(match_n) && $stable(multi_n)));

endmodule

// File: rtl/cam_slice_flags.sv
module cam_slice_flags #(
    parameter int ENTRIES = 8,
    parameter int KEY_W   = 16,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [KEY_W-1:0] wr_key,
    input  logic             cmp_en,
    input  logic [KEY_W-1:0] cmp_key,
    input  logic             bank_sel,
    input  logic             ctl_we,
    input  logic             ctl_full_en,
    input  logic             match_in_n,
    input  logic             full_in_n,
    output logic             dev_match_n,
    output logic             dev_multi_n,
    output logic             match_out_n,
    output logic             full_out_n,
    output logic             holds_next_free,
    output logic [IDX_W-1:0] free_index
);

    logic [ENTRIES-1:0]            valid;
    logic [ENTRIES-1:0][KEY_W-1:0] data;
    logic                          all_valid;
    logic [CNT_W-1:0]              hit_cnt;
    logic                          full_en;

    cam_store #(.ENTRIES(ENTRIES), .KEY_W(KEY_W)) i_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_key    (wr_key),
        .valid     (valid),
        .data      (data),
        .free_idx  (free_index),
        .all_valid (all_valid)
    );

    cam_compare #(.ENTRIES(ENTRIES), .KEY_W(KEY_W)) i_cmp (
        .valid   (valid),
        .data    (data),
        .key     (cmp_key),
        .hit_cnt (hit_cnt)
    );

    cam_flag_fsm #(.CNT_W(CNT_W)) i_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmp_en   (cmp_en),
        .hit_cnt  (hit_cnt),
        .bank_sel (bank_sel),
        .match_n  (dev_match_n),
        .multi_n  (dev_multi_n)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)      full_en <= 1'b1;
        else if (ctl_we) full_en <= ctl_full_en;
    end

    assign match_out_n     = match_in_n & dev_match_n;
    assign full_out_n      = full_en ? !(all_valid && !full_in_n) : full_in_n;
    assign holds_next_free = !full_in_n && full_out_n;

    // R8: own match forces the downstream priority line low
    a_r8_chain_low: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_match_n |-> !match_out_n);

    // R9: an enabled slice with a free entry never reports full
    a_r9_free_not_full: assert property (@(posedge clk) disable iff (!rst_n)
        (full_en && !all_valid) |-> full_out_n);

    // R10: disabled generation passes the upstream full flag through
    a_r10_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
        !full_en |-> (full_out_n == full_in_n));

    // R11: an enabled slice with room below a full upstream holds next free
    a_r11_next_free: assert property (@(posedge clk) disable iff (!rst_n)
        (full_en && !full_in_n && !all_valid) |-> holds_next_free);

endmodule

// File: tb/test_cam_slice_flags.sv
module test_cam_slice_flags;

    localparam int ENTRIES = 8;
    localparam int KEY_W   = 16;
    localparam int IDX_W   = $clog2(ENTRIES);

    logic             clk = 1'b0;
    logic             rst_n;
    logic             wr_en;
    logic [KEY_W-1:0] wr_key;
    logic             cmp_en;
    logic [KEY_W-1:0] cmp_key;
    logic             bank_sel;
    logic             ctl_we;
    logic             ctl_full_en;
    logic             match_in_n;
    logic             full_in_n;
    logic             dev_match_n;
    logic             dev_multi_n;
    logic             match_out_n;
    logic             full_out_n;
    logic             holds_next_free;
    logic [IDX_W-1:0] free_index;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    cam_slice_flags #(.ENTRIES(ENTRIES), .KEY_W(KEY_W)) i_cam_slice_flags (
        .clk             (clk),
        .rst_n           (rst_n),
        .wr_en           (wr_en),
        .wr_key          (wr_key),
        .cmp_en          (cmp_en),
        .cmp_key         (cmp_key),
        .bank_sel        (bank_sel),
        .ctl_we          (ctl_we),
        .ctl_full_en     (ctl_full_en),
        .match_in_n      (match_in_n),
        .full_in_n       (full_in_n),
        .dev_match_n     (dev_match_n),
        .dev_multi_n     (dev_multi_n),
        .match_out_n     (match_out_n),
        .full_out_n      (full_out_n),
        .holds_next_free (holds_next_free),
        .free_index      (free_index)
    );

    // {key, expected dev_match_n, expected dev_multi_n}
    localparam int NVEC = 6;
    localparam logic [KEY_W+1:0] VEC [NVEC] = '{
        {16'h2222, 1'b0, 1'b1},
        {16'h1111, 1'b0, 1'b0},
        {16'h4444, 1'b1, 1'b1},
        {16'h3333, 1'b0, 1'b1},
        {16'h0000, 1'b1, 1'b1},
        {16'h1111, 1'b0, 1'b0}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [KEY_W-1:0] k);
        @(negedge clk);
        wr_en  = 1'b1;
        wr_key = k;
        @(negedge clk);
        wr_en  = 1'b0;
    endtask

    task automatic do_cmp(input logic [KEY_W-1:0] k);
        @(negedge clk);
        cmp_en  = 1'b1;
        cmp_key = k;
        @(negedge clk);
        cmp_en  = 1'b0;
    endtask

    initial begin
        #100000;
        fails++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_key = '0; cmp_en = 1'b0; cmp_key = '0;
        bank_sel = 1'b0; ctl_we = 1'b0; ctl_full_en = 1'b0;
        match_in_n = 1'b1; full_in_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 match", dev_match_n, 1);
        check("R1 multi", dev_multi_n, 1);
        check("R1 free_index", free_index, 0);
        check("R1 full_out", full_out_n, 1);
        rst_n = 1'b1;

        do_write(16'h1111);
        do_write(16'h2222);
        do_write(16'h1111);
        do_write(16'h3333);
        check("R2 free_index after 4 writes", free_index, 4);
        check("R11 holds_next_free with room", holds_next_free, 1);

        // R3/R4 vector table
        for (int i = 0; i < NVEC; i++) begin
            do_cmp(VEC[i][KEY_W+1:2]);
            check("R3 table match", dev_match_n, VEC[i][1]);
            check("R4 table multi", dev_multi_n, VEC[i][0]);
        end

        // R5 hold without compare
        repeat (4) @(negedge clk);
        check("R5 hold match", dev_match_n, 0);
        check("R5 hold multi", dev_multi_n, 0);

        // R6 / R8 chain behaviour
        match_in_n = 1'b0;
        @(negedge clk);
        check("R6 match not gated", dev_match_n, 0);
        check("R8 out low by own match", match_out_n, 0);
        match_in_n = 1'b1;
        do_cmp(16'h4444);
        check("R8 out high when no match", match_out_n, 1);
        match_in_n = 1'b0;
        @(negedge clk);
        check("R8 out low by match_in", match_out_n, 0);
        check("R6 flag high despite match_in", dev_match_n, 1);
        match_in_n = 1'b1;

        // R7 set switch clears flags
        do_cmp(16'h1111);
        check("R7 pre-switch match", dev_match_n, 0);
        @(negedge clk);
        bank_sel = 1'b1;
        @(negedge clk);
        check("R7 switch clears match", dev_match_n, 1);
        check("R7 switch clears multi", dev_multi_n, 1);
        // R7 switch wins over compare at the same edge
        @(negedge clk);
        bank_sel = 1'b0;
        cmp_en = 1'b1;
        cmp_key = 16'h2222;
        @(negedge clk);
        cmp_en = 1'b0;
        check("R7 switch beats compare", dev_match_n, 1);

        // fill slice, R9/R11
        do_write(16'h5555);
        do_write(16'h6666);
        do_write(16'h7777);
        check("R9 one free entry not full", full_out_n, 1);
        do_write(16'h8888);
        check("R2 free_index when full", free_index, 0);
        check("R9 full with upstream full", full_out_n, 0);
        check("R11 no next free when full", holds_next_free, 0);
        full_in_n = 1'b1;
        @(negedge clk);
        check("R9 not full with upstream free", full_out_n, 1);
        check("R11 upstream holds next free", holds_next_free, 0);
        full_in_n = 1'b0;
        do_write(16'h9999);
        do_cmp(16'h9999);
        check("R2 write when full ignored", dev_match_n, 1);
        do_cmp(16'h8888);
        check("R3 last entry matches", dev_match_n, 0);

        // R10 disable full generation
        @(negedge clk);
        ctl_we = 1'b1; ctl_full_en = 1'b0;
        @(negedge clk);
        ctl_we = 1'b0;
        check("R10 disabled full_out low", full_out_n, 0);
        full_in_n = 1'b1;
        @(negedge clk);
        check("R10 disabled follows high", full_out_n, 1);
        full_in_n = 1'b0;
        @(negedge clk);
        check("R11 disabled no next free", holds_next_free, 0);

        // R1 reset again
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset clears flags", dev_match_n, 1);
        check("R1 reset clears entries", free_index, 0);
        check("R1 reset enables full gen", holds_next_free, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule